// File: doc/BRIEF.md
# I2C Target Transmitter with Preload Gating

This block is the read-side engine of an I2C target. It samples the bus through synchronizers and recognises its own 7-bit address. When a controller addresses it for reading, it shifts bytes out of an internal transmit FIFO, most significant bit first. Firmware fills the FIFO through a one-cycle push strobe. Outputs are open-drain style: the block only ever asserts a pull-low enable for SDA or SCL.

In preload mode, firmware first loads the FIFO and then raises a ready bit. Until that bit is set, read requests to the block's address are refused with a NACK. The ready bit drops by itself once the first byte of a read has gone out. If the FIFO runs dry mid-read, the block does one of two things, set by a static control:

- hold SCL low until more data is pushed, or
- flag an underrun and send 0xFF for the rest of that transaction.

Bytes still queued when the controller ends a read stay in the FIFO and lead the next read. Six sticky flags report address match, done, underrun, start error, stop error and low FIFO level.

Top module: `i2c_tgt_tx`

## Requirements
- R1: With `preload_en`=1 and `ready`=0, a read request (R/W bit 1) to `own_addr` is NACKed and no match flag is raised. With `preload_en`=0, such a request is ACKed whatever `ready` is. A write request (R/W bit 0) or a different address is never ACKed.
- R2: Whenever the block ACKs its address, flag bit 0 (address match) becomes 1.
- R3: A one-cycle `ready_set` pulse sets `ready`. Hardware clears `ready` after the eighth bit of the first data byte of a read.
- R4: Data bytes leave in push order, MSB first, one bit per SCL clock. `sda_pull` changes only while SCL is low, except when `enable` drops.
- R5: With `stretch_en`=0, if a byte is requested (the controller ACKed the previous byte) while the FIFO is empty, flag bit 2 (underrun) is set. Every remaining byte of that transaction is then 0xFF.
- R6: With `stretch_en`=1, an empty FIFO at a byte request makes the block hold `scl_pull`=1 until a byte is pushed. That byte is then sent, and flag bit 2 is not set.
- R7: A NACK from the controller after a byte ends the transaction and sets flag bit 1 (done). A FIFO that is empty at that moment does not set flag bit 2.
- R8: FIFO entries not sent by the end of a read remain queued and are sent first by the next read.
- R9: While the block is sending data or waiting for the controller's acknowledge, a START aborts the transfer and sets flag bit 3. A STOP in the same window aborts it and sets flag bit 4.
- R10: Flag bit 5 is set whenever `fifo_level` is less than or equal to `level_thresh`.
- R11: All flags are 0 after reset and stay at 1 until a 1 is written to the matching bit of `flag_clr`. A set event in the same cycle as a clear wins.
- R12: `enable`=0 empties the FIFO (`fifo_level` reads 0) and returns the engine to idle. `fifo_level` always reports the number of queued bytes, never above the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low flushes the FIFO and idles the engine |
| preload_en | input | 1 | Gate read ACKs on the ready bit |
| stretch_en | input | 1 | On empty FIFO, stretch SCL instead of sending 0xFF |
| own_addr | input | 7 | Target address |
| ready_set | input | 1 | Pulse that sets the ready bit |
| ready | output | 1 | Ready bit |
| push_valid | input | 1 | Push strobe into the transmit FIFO |
| push_data | input | 8 | Byte to push |
| fifo_level | output | LW | Queued byte count |
| level_thresh | input | LW | Low-level threshold |
| flag_clr | input | 6 | Write-one-to-clear strobes for the flags |
| flags | output | 6 | Sticky flags: 0 match, 1 done, 2 underrun, 3 start error, 4 stop error, 5 low level |
| scl_in | input | 1 | SCL as seen on the bus |
| sda_in | input | 1 | SDA as seen on the bus |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |

## Verification
A modelled controller on a wired-AND bus runs reads against a queue model of the FIFO, with every received byte compared to the model.

Several address patterns show how the block gates its ACK:

- its own read address before and after ready, which separates gating on ready from plain address decode;
- its write address and a neighbouring address, which must always be refused;
- a read with preload off, which shows the gate can be bypassed.

Several read lengths exercise the FIFO paths:

- a partial drain followed by a second read, which separates retained data from lost data;
- reads that run past the FIFO contents, once with stretching off and once with it on, which separates the 0xFF fill from clock stretching.

A STOP and a START injected mid-byte show that the abort detection works.

// File: rtl/i2ct_pkg.sv
// Package: shared types and flag positions for the I2C target transmitter.
// Assumes: flag bit order is visible to firmware and to the bench.
package i2ct_pkg;
    localparam int NFLAGS  = 6;
    localparam int F_MATCH = 0;
    localparam int F_DONE  = 1;
    localparam int F_UNDER = 2;
    localparam int F_SERR  = 3;
    localparam int F_PERR  = 4;
    localparam int F_LOW   = 5;
    localparam int NEV     = 5;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_AACK  = 3'd2,
        ST_FETCH = 3'd3,
        ST_TX    = 3'd4,
        ST_MACK  = 3'd5,
        ST_NEXT  = 3'd6
    } eng_state_t;
endpackage

// File: rtl/i2ct_sync.sv
// Module: multi-stage synchronizer for bus lines.
// Assumes: STAGES >= 1; reset value is the idle bus level (high).
module i2ct_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: shift the line one stage further into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '1;
            else        pipe[g] <= (g == 0) ? d : pipe[(g == 0) ? 0 : g-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_fifo.sv
// Module: transmit FIFO with show-ahead head and level count.
// Assumes: DEPTH is a power of two; pushes when full and pops when empty are dropped.
module i2ct_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign do_push = push && (level != LW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Purpose: store an accepted byte.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Purpose: advance pointers and track the level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/i2ct_engine.sv
// Module: bus-condition detector and transmit state machine.
// Assumes: synchronized SCL/SDA sampled at >= 8x the SCL rate; all outputs
// registered; ev[] pulses one cycle per event, indexed like the flags.
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           preload_en,
    input  logic           stretch_en,
    input  logic           ready,
    input  logic [6:0]     own_addr,
    input  logic           scl_s,
    input  logic           sda_s,
    input  logic           fifo_empty,
    input  logic [7:0]     fifo_dout,
    output logic           fifo_pop,
    output logic           sda_drv,
    output logic           scl_drv,
    output logic           clr_ready,
    output logic [NEV-1:0] ev
);
    eng_state_t state;
    logic       scl_q, sda_q, uf, first;
    logic [7:0] sreg;
    logic [3:0] cnt;
    logic       scl_rise, scl_fall, start_c, stop_c, in_tx, hit;
    logic [7:0] nbyte;

    assign scl_rise = scl_s && !scl_q;
    assign scl_fall = !scl_s && scl_q;
    assign start_c  = scl_s && scl_q && sda_q && !sda_s;
    assign stop_c   = scl_s && scl_q && !sda_q && sda_s;
    assign in_tx    = (state == ST_TX) || (state == ST_MACK) ||
                      (state == ST_NEXT) || (state == ST_FETCH);
    assign hit      = (sreg[7:1] == own_addr) && sreg[0] && (!preload_en || ready);
    assign nbyte    = uf ? 8'hFF : (fifo_empty ? 8'hFF : fifo_dout);

    // Purpose: sequence address decode, byte shifting and acknowledge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
            sda_drv <= 1'b0; scl_drv <= 1'b0; uf <= 1'b0; first <= 1'b0;
            sreg <= '0; cnt <= '0; ev <= '0; clr_ready <= 1'b0; fifo_pop <= 1'b0;
        end else begin
            scl_q     <= scl_s;
            sda_q     <= sda_s;
            ev        <= '0;
            clr_ready <= 1'b0;
            fifo_pop  <= 1'b0;
            if (!enable) begin
                state <= ST_IDLE; sda_drv <= 1'b0; scl_drv <= 1'b0; uf <= 1'b0;
            end else if (start_c) begin
                if (in_tx) begin
                    ev[F_SERR] <= 1'b1;
                    state      <= ST_IDLE;
                end else begin
                    state <= ST_ADDR;
                    cnt   <= '0;
                end
                sda_drv <= 1'b0; scl_drv <= 1'b0; uf <= 1'b0;
            end else if (stop_c) begin
                if (in_tx) ev[F_PERR] <= 1'b1;
                state <= ST_IDLE; sda_drv <= 1'b0; scl_drv <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sreg <= {sreg[6:0], sda_s};
                            cnt  <= cnt + 1'b1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (hit) begin
                                sda_drv     <= 1'b1;
                                ev[F_MATCH] <= 1'b1;
                                first       <= 1'b1;
                                state       <= ST_AACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: if (scl_fall) begin
                        sda_drv <= 1'b0;
                        state   <= ST_FETCH;
                    end
                    ST_FETCH: begin
                        if (!uf && fifo_empty && stretch_en) begin
                            scl_drv <= 1'b1;
                        end else begin
                            if (!uf && fifo_empty) begin
                                ev[F_UNDER] <= 1'b1;
                                uf          <= 1'b1;
                            end
                            fifo_pop <= !uf && !fifo_empty;
                            sreg     <= nbyte;
                            sda_drv  <= !nbyte[7];
                            cnt      <= '0;
                            scl_drv  <= 1'b0;
                            state    <= ST_TX;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_drv   <= 1'b0;
                            clr_ready <= first;
                            first     <= 1'b0;
                            state     <= ST_MACK;
                        end else begin
                            sreg    <= {sreg[6:0], 1'b0};
                            sda_drv <= !sreg[6];
                            cnt     <= cnt + 1'b1;
                        end
                    end
                    ST_MACK: if (scl_rise) begin
                        if (sda_s) begin
                            ev[F_DONE] <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            state <= ST_NEXT;
                        end
                    end
                    ST_NEXT: if (scl_fall) state <= ST_FETCH;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_tgt_tx.sv
// Module: I2C target transmitter top. Joins synchronizers, FIFO and engine,
// and owns the ready bit and the sticky flags.
// Assumes: clk runs at least 8x SCL; flags are write-one-to-clear, set wins.
module i2c_tgt_tx
    import i2ct_pkg::*;
#(
    parameter int  DEPTH       = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int LW          = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              preload_en,
    input  logic              stretch_en,
    input  logic [6:0]        own_addr,
    input  logic              ready_set,
    output logic              ready,
    input  logic              push_valid,
    input  logic [7:0]        push_data,
    output logic [LW-1:0]     fifo_level,
    input  logic [LW-1:0]     level_thresh,
    input  logic [NFLAGS-1:0] flag_clr,
    output logic [NFLAGS-1:0] flags,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull
);
    logic [1:0]     bus_s;
    logic           fifo_empty, fifo_pop, clr_ready;
    logic [7:0]     fifo_dout;
    logic [NEV-1:0] ev;

    i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(bus_s)
    );

    i2ct_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!enable), .push(push_valid),
        .din(push_data), .pop(fifo_pop), .dout(fifo_dout),
        .empty(fifo_empty), .level(fifo_level)
    );

    i2ct_engine u_eng (
        .clk(clk), .rst_n(rst_n), .enable(enable), .preload_en(preload_en),
        .stretch_en(stretch_en), .ready(ready), .own_addr(own_addr),
        .scl_s(bus_s[1]), .sda_s(bus_s[0]), .fifo_empty(fifo_empty),
        .fifo_dout(fifo_dout), .fifo_pop(fifo_pop), .sda_drv(sda_pull),
        .scl_drv(scl_pull), .clr_ready(clr_ready), .ev(ev)
    );

    // Purpose: firmware sets ready, hardware clears it after the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         ready <= 1'b0;
        else if (ready_set) ready <= 1'b1;
        else if (clr_ready) ready <= 1'b0;
    end

    // Purpose: sticky flags, write-one-to-clear, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) |
                             {(fifo_level <= level_thresh), ev};
    end
endmodule

// File: rtl/i2ct_tx_chk.sv
// Module: property checker for i2c_tgt_tx, attached by bind.
// Assumes: observes top-level ports plus the engine's ready-clear strobe.
module i2ct_tx_chk #(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          preload_en,
    input logic          stretch_en,
    input logic          ready,
    input logic          clr_rdy,
    input logic          scl_in,
    input logic          sda_pull,
    input logic [LW-1:0] fifo_level,
    input logic [5:0]    flag_clr,
    input logic [5:0]    flags
);
    // R1, R2: a match flag only rises when the gate allowed the ACK
    a_r1_match_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> (!$past(preload_en) || $past(ready)));

    // R3: ready only drops on the engine's first-byte strobe
    a_r3_ready_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(clr_rdy));

    // R4: data line moves only while SCL is low
    a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !$stable(sda_pull)) |-> !$past(scl_in));

    // R6: no underrun flag is raised while stretching is selected
    a_r6_no_underrun_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> !$past(stretch_en));

    // R11: done flag stays until cleared
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !flag_clr[1]) |=> flags[1]);

    // R11: underrun flag stays until cleared
    a_r11_under_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && !flag_clr[2]) |=> flags[2]);

    // R12: level never exceeds depth
    a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));
endmodule

bind i2c_tgt_tx i2ct_tx_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .preload_en(preload_en),
    .stretch_en(stretch_en), .ready(ready), .clr_rdy(clr_ready),
    .scl_in(scl_in), .sda_pull(sda_pull), .fifo_level(fifo_level),
    .flag_clr(flag_clr), .flags(flags)
);

// File: tb/test_i2c_tgt_tx.sv
// Bench: behavioural I2C controller on a wired-AND bus plus a queue model of the FIFO.
module test_i2c_tgt_tx;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       enable = 1'b0, preload_en = 1'b1, stretch_en = 1'b0;
    logic       ready_set = 1'b0, push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic [6:0] own_addr = 7'h2A;
    logic [3:0] level_thresh = '0;
    logic [5:0] flag_clr = '0;
    logic       ready, scl_pull, sda_pull;
    logic [3:0] fifo_level;
    logic [5:0] flags;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    wire        scl_bus = ~(m_scl_low | scl_pull);
    wire        sda_bus = ~(m_sda_low | sda_pull);

    int compared = 0, mismatched = 0;
    logic [7:0] model_q [$];
    localparam int Q = 12;

    i2c_tgt_tx i_i2c_tgt_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .preload_en(preload_en),
        .stretch_en(stretch_en), .own_addr(own_addr), .ready_set(ready_set),
        .ready(ready), .push_valid(push_valid), .push_data(push_data),
        .fifo_level(fifo_level), .level_thresh(level_thresh),
        .flag_clr(flag_clr), .flags(flags), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        push_valid = 1'b1; push_data = d; tick(1);
        push_valid = 1'b0; model_q.push_back(d);
    endtask

    task automatic clr(input logic [5:0] m);
        flag_clr = m; tick(1); flag_clr = '0; tick(1);
    endtask

    task automatic rdy();
        ready_set = 1'b1; tick(1); ready_set = 1'b0; tick(1);
    endtask

    task automatic wait_high();
        while (!scl_bus) tick(1);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b0; tick(Q);
        m_sda_low = 1'b0; tick(2*Q);
    endtask

    task automatic m_wbit(input logic b);
        m_sda_low = !b; tick(Q);
        m_scl_low = 1'b0; wait_high(); tick(2*Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic m_rbit(output logic b);
        m_sda_low = 1'b0; tick(Q);
        m_scl_low = 1'b0; wait_high(); tick(Q);
        b = sda_bus; tick(Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic m_addr(input logic [6:0] a, input logic rw, output logic ack);
        logic b;
        for (int i = 6; i >= 0; i--) m_wbit(a[i]);
        m_wbit(rw);
        m_rbit(b);
        ack = !b;
    endtask

    task automatic m_rbyte(input logic ack_it, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_wbit(!ack_it);
    endtask

    // Full read of n bytes, last one NACKed; bytes compared with the queue model.
    task automatic read_txn(input string tag, input int n, input logic exp_ack);
        logic ack;
        logic uf = 1'b0;
        logic [7:0] d, e;
        m_start();
        m_addr(own_addr, 1'b1, ack);
        chk({tag, " ack"}, ack, exp_ack);
        if (ack) begin
            for (int i = 0; i < n; i++) begin
                m_rbyte(i < n-1, d);
                if (uf || model_q.size() == 0) begin
                    e = 8'hFF; uf = 1'b1;
                end else begin
                    e = model_q.pop_front();
                end
                chk({tag, " data"}, d, e);
            end
        end
        m_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        tick(5);
        rst_n = 1'b1; enable = 1'b1;
        tick(3);
        // R11 reset state (bit 5 may already reflect the empty FIFO)
        chk("R11 reset flags", flags[4:0], 0);
        chk("R12 reset level", fifo_level, 0);
        chk("R3 reset ready", ready, 0);
        chk("R4 reset sda_pull", sda_pull, 0);
        chk("R6 reset scl_pull", scl_pull, 0);

        // R1: preload gating refuses the read before ready
        push(8'hA1); push(8'hB2); push(8'hC3); push(8'hD4); push(8'hE5);
        read_txn("R1 unready", 3, 1'b0);
        chk("R1 no match flag", flags[0], 0);
        chk("R12 level untouched", fifo_level, 5);

        // R1: write and foreign addresses refused even when ready
        rdy();
        m_start(); m_addr(own_addr, 1'b0, ack); m_stop();
        chk("R1 write nack", ack, 0);
        m_start(); m_addr(7'h15, 1'b1, ack); m_stop();
        chk("R1 mismatch nack", ack, 0);
        chk("R3 ready set", ready, 1);

        // R2 R3 R4 R7: read three bytes of five
        read_txn("R4 partial", 3, 1'b1);
        chk("R2 match flag", flags[0], 1);
        chk("R7 done flag", flags[1], 1);
        chk("R7 no underrun", flags[2], 0);
        chk("R3 ready cleared", ready, 0);
        chk("R8 level left", fifo_level, 2);
        clr(6'h3F);
        chk("R11 done cleared", flags[1], 0);

        // R8: retained bytes go first; R7 empty at NACK is no underrun
        rdy();
        read_txn("R8 retained", 2, 1'b1);
        chk("R8 level drained", fifo_level, 0);
        chk("R7 empty at nack", flags[2], 0);

        // R5: underrun fills with 0xFF
        push(8'h3C); rdy();
        read_txn("R5 underrun", 3, 1'b1);
        chk("R5 underrun flag", flags[2], 1);

        // R6: stretching holds SCL until a push
        clr(6'h3F); stretch_en = 1'b1; rdy();
        m_start(); m_addr(own_addr, 1'b1, ack);
        chk("R6 ack", ack, 1);
        fork
            m_rbyte(1'b0, d);
            begin
                tick(400);
                chk("R6 scl held", scl_pull, 1);
                push(8'h5A);
            end
        join
        void'(model_q.pop_front());
        chk("R6 stretched data", d, 8'h5A);
        m_stop();
        chk("R6 no underrun", flags[2], 0);
        stretch_en = 1'b0;

        // R1: preload off ignores ready
        preload_en = 1'b0; push(8'h77);
        read_txn("R1 preload off", 1, 1'b1);
        preload_en = 1'b1;

        // R9: STOP while a data byte is pending
        clr(6'h3F); push(8'h81); push(8'h92); rdy();
        m_start(); m_addr(own_addr, 1'b1, ack);
        m_rbyte(1'b1, d);
        chk("R9 first byte", d, 8'h81);
        m_stop();
        void'(model_q.pop_front()); void'(model_q.pop_front());
        chk("R9 stop error", flags[4], 1);
        chk("R9 no start error", flags[3], 0);

        // R9: START while sending a 1 bit
        clr(6'h3F); push(8'hFF); rdy();
        m_start(); m_addr(own_addr, 1'b1, ack);
        m_sda_low = 1'b0; tick(Q);
        m_scl_low = 1'b0; wait_high(); tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b1; tick(Q);
        m_stop();
        void'(model_q.pop_front());
        chk("R9 start error", flags[3], 1);
        chk("R9 stop after abort", flags[4], 0);

        // R10: low-level flag follows the threshold
        level_thresh = 4'd1; clr(6'h3F); tick(2);
        chk("R10 low at empty", flags[5], 1);
        push(8'h11); push(8'h22); push(8'h33);
        clr(6'h20); tick(2);
        chk("R10 above thresh", flags[5], 0);

        // R12: disable flushes
        enable = 1'b0; tick(2);
        chk("R12 flushed", fifo_level, 0);
        model_q.delete();
        enable = 1'b1; tick(3);
        chk("R10 low after flush", flags[5], 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule